// File: doc/BRIEF.md
# Nibble-Serial Byte ALU

This block computes an 8-bit arithmetic or logic result with one 4-bit datapath that it uses twice. When `start` is seen, the two operand bytes are captured. Operand A may be shifted or rotated by one bit as it is captured. For subtracting operations, operand B is inverted as it is captured. The low nibbles then go through the 4-bit core, and that partial result and its carry are held in latches. In the next cycle the high nibbles go through the same core, with the held carry as their carry-in. The stored low nibble and the new high nibble together form the byte result, and the flags are registered at the same time.

A controlling state machine has three named states. `ST_IDLE` waits for `start` and loads the operands; its transition on `start` is named *accept*. `ST_LOW` runs the low-nibble pass; its transition is named *low_done* and always goes to `ST_HIGH`. `ST_HIGH` runs the high-nibble pass and commits the result; its transition is named *commit* and always returns to `ST_IDLE`. The `done` strobe is registered from *commit*. A surrounding datapath supplies the operands and the operation code and collects the result and the flags.

Top module: `nib_alu_top`

## Requirements
- R1: `op_sel` 0 (add) gives A+B and `op_sel` 1 (add with carry) gives A+B+`carry_in`. `flag_c` is the carry out of bit 7.
- R2: `op_sel` 2 (subtract) gives A-B and `op_sel` 3 (subtract with borrow) gives A-B-`carry_in`, both modulo 256. `flag_c` is set when a borrow out of bit 7 occurs.
- R3: `flag_h` is the carry (for add) or the borrow (for subtract) out of bit 3, which is the carry between the low pass and the high pass.
- R4: `op_sel` 4, 5 and 6 give A AND B, A OR B and A XOR B. For these, `flag_c` and `flag_h` are 0.
- R5: `flag_z` is 1 exactly when all eight bits of the computed value are zero. `flag_s` equals bit 7 of the computed value.
- R6: `op_sel` 7 (compare) updates all flags exactly as subtract would, but `result` keeps its previous value. In all operations, `result` changes only in the cycle in which `done` is high.
- R7: `shift_sel` transforms operand A before the passes: 0 leaves it unchanged, 1 shifts it left with a 0 fill, 2 shifts it right with a 0 fill, and 3 rotates it left by one.
- R8: When `start` is sampled in `ST_IDLE` at clock edge k, `done` is high for exactly one cycle after edge k+2, and the result and the flags are valid in that cycle.
- R9: A `start` that arrives while an operation is in progress (`ST_LOW` or `ST_HIGH`) is ignored. It does not change the result and produces no extra `done`.
- R10: After reset, `result` and all the flags are 0, `done` is 0, and the block is in `ST_IDLE`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation (accepted only in `ST_IDLE`) |
| op_sel | input | 3 | Operation code (see R1, R2, R4, R6) |
| shift_sel | input | 2 | Transform applied to operand A when it is loaded (see R7) |
| opd_a | input | 8 | Operand A |
| opd_b | input | 8 | Operand B |
| carry_in | input | 1 | Carry or borrow input for add with carry and subtract with borrow |
| result | output | 8 | Registered byte result |
| flag_c | output | 1 | Carry or borrow out of bit 7 |
| flag_h | output | 1 | Carry or borrow out of bit 3 |
| flag_z | output | 1 | Zero flag |
| flag_s | output | 1 | Sign flag |
| done | output | 1 | One-cycle completion strobe |

## Verification
The assertions check on every cycle that `done` is a single-cycle pulse that follows an accepted `start` by the fixed latency. They also check that `result` moves only with `done`, that logic operations leave carry and half-carry clear, and that zero and sign agree with the result byte. The arithmetic values themselves can only be shown by the bench's scenarios. These are the carry and borrow across the nibble boundary, the compare operation that leaves `result` untouched, each shift variant, and a `start` dropped while the block is busy.

// File: rtl/nib_alu_pkg.sv
package nib_alu_pkg;

    typedef enum logic [2:0] {
        OP_ADD = 3'd0,
        OP_ADC = 3'd1,
        OP_SUB = 3'd2,
        OP_SBC = 3'd3,
        OP_AND = 3'd4,
        OP_OR  = 3'd5,
        OP_XOR = 3'd6,
        OP_CMP = 3'd7
    } alu_op_e;

    typedef enum logic [1:0] {
        SH_NONE  = 2'd0,
        SH_LEFT  = 2'd1,
        SH_RIGHT = 2'd2,
        SH_ROTL  = 2'd3
    } shift_e;

    typedef enum logic [1:0] {
        FN_ADD = 2'd0,
        FN_AND = 2'd1,
        FN_OR  = 2'd2,
        FN_XOR = 2'd3
    } core_fn_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOW  = 2'd1,
        ST_HIGH = 2'd2
    } state_e;

    function automatic logic op_is_sub(input alu_op_e op);
        return (op == OP_SUB) || (op == OP_SBC) || (op == OP_CMP);
    endfunction

    function automatic logic op_is_arith(input alu_op_e op);
        return (op == OP_ADD) || (op == OP_ADC) || op_is_sub(op);
    endfunction

    function automatic core_fn_e op_core_fn(input alu_op_e op);
        case (op)
            OP_AND:  return FN_AND;
            OP_OR:   return FN_OR;
            OP_XOR:  return FN_XOR;
            default: return FN_ADD;
        endcase
    endfunction

endpackage

// File: rtl/nib_slice.sv
module nib_slice
    import nib_alu_pkg::*;
(
    input  logic     a,
    input  logic     b,
    input  logic     ci,
    input  core_fn_e fn,
    output logic     y,
    output logic     co
);
    always_comb begin
        y  = 1'b0;
        co = 1'b0;
        unique case (fn)
            FN_ADD: begin
                y  = a ^ b ^ ci;
                co = (a & b) | (a & ci) | (b & ci);
            end
            FN_AND: y = a & b;
            FN_OR:  y = a | b;
            FN_XOR: y = a ^ b;
        endcase
    end
endmodule

// File: rtl/nib_core.sv
module nib_core
    import nib_alu_pkg::*;
#(
    parameter int W = 4
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         ci,
    input  core_fn_e     fn,
    output logic [W-1:0] y,
    output logic         co
);
    logic [W:0] chain;
    assign chain[0] = ci;

    for (genvar i = 0; i < W; i++) begin : g_slice
        nib_slice u_slice (
            .a  (a[i]),
            .b  (b[i]),
            .ci (chain[i]),
            .fn (fn),
            .y  (y[i]),
            .co (chain[i+1])
        );
    end

    assign co = chain[W];
endmodule

// File: rtl/nib_alu_ctl.sv
module nib_alu_ctl
    import nib_alu_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic load,
    output logic sel_high,
    output logic lat_low,
    output logic lat_fin
);
    state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d  = state_q;
        load     = 1'b0;
        sel_high = 1'b0;
        lat_low  = 1'b0;
        lat_fin  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                load = start;
                if (start) state_d = ST_LOW;       // accept
            end
            ST_LOW: begin
                lat_low = 1'b1;
                state_d = ST_HIGH;                 // low_done
            end
            ST_HIGH: begin
                sel_high = 1'b1;
                lat_fin  = 1'b1;
                state_d  = ST_IDLE;                // commit
            end
            default: state_d = ST_IDLE;
        endcase
    end
endmodule

// File: rtl/nib_alu_top.sv
module nib_alu_top
    import nib_alu_pkg::*;
#(
    parameter int NIB_W = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [2:0]           op_sel,
    input  logic [1:0]           shift_sel,
    input  logic [2*NIB_W-1:0]   opd_a,
    input  logic [2*NIB_W-1:0]   opd_b,
    input  logic                 carry_in,
    output logic [2*NIB_W-1:0]   result,
    output logic                 flag_c,
    output logic                 flag_h,
    output logic                 flag_z,
    output logic                 flag_s,
    output logic                 done
);
    localparam int DATA_W = 2 * NIB_W;

    logic load, sel_high, lat_low, lat_fin;

    nib_alu_ctl u_ctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .load     (load),
        .sel_high (sel_high),
        .lat_low  (lat_low),
        .lat_fin  (lat_fin)
    );

    // Operand shaping at load time
    alu_op_e           op_in;
    logic [DATA_W-1:0] a_shaped, b_shaped;
    logic              c0_in;

    assign op_in = alu_op_e'(op_sel);

    always_comb begin
        unique case (shift_e'(shift_sel))
            SH_NONE:  a_shaped = opd_a;
            SH_LEFT:  a_shaped = {opd_a[DATA_W-2:0], 1'b0};
            SH_RIGHT: a_shaped = {1'b0, opd_a[DATA_W-1:1]};
            SH_ROTL:  a_shaped = {opd_a[DATA_W-2:0], opd_a[DATA_W-1]};
        endcase
        b_shaped = op_is_sub(op_in) ? ~opd_b : opd_b;
        unique case (op_in)
            OP_ADC:         c0_in = carry_in;
            OP_SUB, OP_CMP: c0_in = 1'b1;
            OP_SBC:         c0_in = ~carry_in;
            default:        c0_in = 1'b0;
        endcase
    end

    // Operand latches and inter-pass state
    logic [DATA_W-1:0] a_q, b_q;
    alu_op_e           op_q;
    logic              c0_q;
    logic [NIB_W-1:0]  lo_q;
    logic              hc_q;

    // Shared nibble datapath
    logic [NIB_W-1:0] core_a, core_b, core_y;
    logic             core_ci, core_co;

    assign core_a  = sel_high ? a_q[DATA_W-1:NIB_W] : a_q[NIB_W-1:0];
    assign core_b  = sel_high ? b_q[DATA_W-1:NIB_W] : b_q[NIB_W-1:0];
    assign core_ci = sel_high ? hc_q : c0_q;

    nib_core #(.W(NIB_W)) u_core (
        .a  (core_a),
        .b  (core_b),
        .ci (core_ci),
        .fn (op_core_fn(op_q)),
        .y  (core_y),
        .co (core_co)
    );

    logic [DATA_W-1:0] joined;
    assign joined = {core_y, lo_q};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_q    <= '0;
            b_q    <= '0;
            op_q   <= OP_ADD;
            c0_q   <= 1'b0;
            lo_q   <= '0;
            hc_q   <= 1'b0;
            result <= '0;
            flag_c <= 1'b0;
            flag_h <= 1'b0;
            flag_z <= 1'b0;
            flag_s <= 1'b0;
            done   <= 1'b0;
        end else begin
            done <= lat_fin;
            if (load) begin
                a_q  <= a_shaped;
                b_q  <= b_shaped;
                op_q <= op_in;
                c0_q <= c0_in;
            end
            if (lat_low) begin
                lo_q <= core_y;
                hc_q <= core_co;
            end
            if (lat_fin) begin
                if (op_q != OP_CMP) result <= joined;
                flag_z <= (joined == '0);
                flag_s <= joined[DATA_W-1];
                if (op_is_arith(op_q)) begin
                    flag_c <= op_is_sub(op_q) ? ~core_co : core_co;
                    flag_h <= op_is_sub(op_q) ? ~hc_q : hc_q;
                end else begin
                    flag_c <= 1'b0;
                    flag_h <= 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/nib_alu_chk.sv
module nib_alu_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic [2:0] op_sel,
    input logic [7:0] result,
    input logic       flag_c,
    input logic       flag_h,
    input logic       flag_z,
    input logic       flag_s,
    input logic       done
);
    assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(start, 3));

    assert_logic_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (done && ($past(op_sel, 3) >= 3'd4) && ($past(op_sel, 3) <= 3'd6))
            |-> (!flag_c && !flag_h));

    assert_zero_sign_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && ($past(op_sel, 3) != 3'd7))
            |-> ((flag_z == (result == 8'h00)) && (flag_s == result[7])));

    assert_hold_result_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(result));
endmodule

bind nib_alu_top nib_alu_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .op_sel  (op_sel),
    .result  (result),
    .flag_c  (flag_c),
    .flag_h  (flag_h),
    .flag_z  (flag_z),
    .flag_s  (flag_s),
    .done    (done)
);

// File: tb/tb_nib_alu_top.sv
module tb_nib_alu_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [2:0] op_sel = '0;
    logic [1:0] shift_sel = '0;
    logic [7:0] opd_a = '0, opd_b = '0;
    logic       carry_in = 1'b0;
    logic [7:0] result;
    logic       flag_c, flag_h, flag_z, flag_s, done;

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] exp_res = 8'h00;

    always #(CLK_PERIOD/2) clk = ~clk;

    nib_alu_top dut (
        .clk(clk), .rst_n(rst_n), .start(start), .op_sel(op_sel),
        .shift_sel(shift_sel), .opd_a(opd_a), .opd_b(opd_b), .carry_in(carry_in),
        .result(result), .flag_c(flag_c), .flag_h(flag_h), .flag_z(flag_z),
        .flag_s(flag_s), .done(done)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Reference from requirements: returns {C,H,Z,S,value}
    function automatic logic [11:0] model(input logic [2:0] op, input logic [1:0] sh,
                                          input logic [7:0] a_in, input logic [7:0] b,
                                          input logic ci);
        logic [7:0] a, v;
        logic [8:0] w;
        logic [4:0] n;
        logic c, h, k;
        case (sh)
            2'd1: a = {a_in[6:0], 1'b0};
            2'd2: a = {1'b0, a_in[7:1]};
            2'd3: a = {a_in[6:0], a_in[7]};
            default: a = a_in;
        endcase
        c = 1'b0; h = 1'b0; v = 8'h00;
        case (op)
            3'd0, 3'd1: begin
                k = (op == 3'd1) ? ci : 1'b0;
                w = {1'b0, a} + {1'b0, b} + {8'h00, k};
                n = {1'b0, a[3:0]} + {1'b0, b[3:0]} + {4'h0, k};
                v = w[7:0]; c = w[8]; h = n[4];
            end
            3'd2, 3'd3, 3'd7: begin
                k = (op == 3'd3) ? ci : 1'b0;
                w = {1'b0, a} - {1'b0, b} - {8'h00, k};
                n = {1'b0, a[3:0]} - {1'b0, b[3:0]} - {4'h0, k};
                v = w[7:0]; c = w[8]; h = n[4];
            end
            3'd4: v = a & b;
            3'd5: v = a | b;
            default: v = a ^ b;
        endcase
        return {c, h, (v == 8'h00), v[7], v};
    endfunction

    // Runs one operation and checks latency, result and flags
    task automatic run_op(input string req, input logic [2:0] op, input logic [1:0] sh,
                          input logic [7:0] a, input logic [7:0] b, input logic ci);
        logic [11:0] m;
        m = model(op, sh, a, b, ci);
        @(negedge clk);
        op_sel = op; shift_sel = sh; opd_a = a; opd_b = b; carry_in = ci; start = 1'b1;
        @(posedge clk);
        @(negedge clk); start = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check("R8", "done early", int'(done), 0);
        @(posedge clk);
        @(negedge clk);
        check("R8", "done", int'(done), 1);
        if (op != 3'd7) exp_res = m[7:0];
        check(req, "result", int'(result), int'(exp_res));
        check(req, "flag_c", int'(flag_c), int'(m[11]));
        check(req, "flag_h", int'(flag_h), int'(m[10]));
        check("R5", "flag_z", int'(flag_z), int'(m[9]));
        check("R5", "flag_s", int'(flag_s), int'(m[8]));
        @(posedge clk);
        @(negedge clk);
        check("R8", "done width", int'(done), 0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R10", "result", int'(result), 0);
        check("R10", "flags", int'({flag_c, flag_h, flag_z, flag_s}), 0);
        check("R10", "done", int'(done), 0);
    endtask

    task automatic t_add();
        run_op("R1", 3'd0, 2'd0, 8'h0F, 8'h01, 1'b0);  // R3 half carry
        run_op("R1", 3'd0, 2'd0, 8'hFF, 8'h01, 1'b0);  // carry, zero
        run_op("R1", 3'd1, 2'd0, 8'h3A, 8'h45, 1'b1);  // adc to 0x80
        run_op("R1", 3'd1, 2'd0, 8'h12, 8'h34, 1'b0);
    endtask

    task automatic t_sub();
        run_op("R2", 3'd2, 2'd0, 8'h10, 8'h01, 1'b0);  // R3 half borrow
        run_op("R2", 3'd2, 2'd0, 8'h00, 8'h01, 1'b0);  // full borrow
        run_op("R2", 3'd3, 2'd0, 8'h50, 8'h20, 1'b1);
        run_op("R2", 3'd3, 2'd0, 8'h88, 8'h08, 1'b0);
    endtask

    task automatic t_half();
        run_op("R3", 3'd0, 2'd0, 8'h08, 8'h08, 1'b0);
        run_op("R3", 3'd2, 2'd0, 8'h23, 8'h05, 1'b0);
    endtask

    task automatic t_logic();
        run_op("R4", 3'd4, 2'd0, 8'hF0, 8'h3C, 1'b1);
        run_op("R4", 3'd5, 2'd0, 8'h00, 8'h00, 1'b1);
        run_op("R4", 3'd6, 2'd0, 8'hA5, 8'h5A, 1'b0);
    endtask

    task automatic t_compare();
        run_op("R6", 3'd0, 2'd0, 8'h11, 8'h22, 1'b0);  // result 0x33
        run_op("R6", 3'd7, 2'd0, 8'h42, 8'h42, 1'b0);  // equal
        run_op("R6", 3'd7, 2'd0, 8'h01, 8'h02, 1'b0);  // borrow
    endtask

    task automatic t_shift();
        run_op("R7", 3'd0, 2'd1, 8'h81, 8'h00, 1'b0);
        run_op("R7", 3'd0, 2'd2, 8'h81, 8'h00, 1'b0);
        run_op("R7", 3'd0, 2'd3, 8'h81, 8'h00, 1'b0);
        run_op("R7", 3'd0, 2'd1, 8'h48, 8'h01, 1'b0);
    endtask

    // R9: start held during busy cycles must not disturb the running op
    task automatic t_busy_start();
        @(negedge clk);
        op_sel = 3'd0; shift_sel = 2'd0; opd_a = 8'h21; opd_b = 8'h13; carry_in = 1'b0;
        start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        op_sel = 3'd6; opd_a = 8'hFF; opd_b = 8'h0F;   // start stays high
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        check("R9", "done", int'(done), 1);
        check("R9", "result", int'(result), 8'h34);
        exp_res = 8'h34;
        for (int i = 0; i < 4; i++) begin
            @(posedge clk);
            @(negedge clk);
            check("R9", "no extra done", int'(done), 0);
            check("R9", "result held", int'(result), 8'h34);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        t_reset();
        @(negedge clk); rst_n = 1'b1;
        t_reset();
        t_add();
        t_sub();
        t_half();
        t_logic();
        t_compare();
        t_shift();
        t_busy_start();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule